// File: doc/BRIEF.md
# Synchronous Burst ROM Read Controller

This block holds the command decoding, the timing guards and the read datapath of a synchronous read-only memory. The address bus is multiplexed. Every control and address input is sampled on the rising clock edge. A host writes the latency and burst settings into a mode register. It then opens a row with an activate command and starts a burst with a read command that carries the column. After the programmed column latency, the block returns a burst of 4 or 8 words, one per clock, in either sequential or interleaved order.

A word-mode pin chooses the data organisation. In 32-bit mode the column is 8 bits wide. In 16-bit mode the column gains one bit, which selects one half of a 32-bit storage word. The storage is a parameterised array whose contents are a fixed function of the index. A clock-enable input freezes the whole block. A mask input blanks single output words without stopping the burst. Commands that break a timing rule raise a one-cycle error flag and have no other effect.

Top module: `burst_rom_ctrl`

## Requirements
- R1: After reset valid_o, err_o and data_o are all 0. The mode register then holds row latency 1, column latency 3, burst length 4 and sequential order.
- R2: A command is taken only on an edge with cke_i and sel_i high and exactly one strobe high: mode_stb_i means mode set, row_stb_i means activate, col_stb_i means read. When sel_i is low, the strobes have no effect.
- R3: A mode set loads these fields from addr_i: bit 0 selects burst length (0 = 4, 1 = 8), bit 1 selects order (0 = sequential, 1 = interleaved), bit 2 selects row latency (0 = 1, 1 = 2), and bits 4:3 hold column latency minus 3.
- R4: If a read is taken at edge e, the first word is valid after edge e+CL. One word follows on each clock until BL words have been sent, and then valid_o falls.
- R5: Beat k of a burst uses a column whose bits above the burst field equal those of the start column. Its low log2(BL) bits are (s+k) mod BL in sequential order and s XOR k in interleaved order, where s is the start column's low bits.
- R6: In 32-bit mode (word_mode_i low at the read) the column is addr_i[7:0]. The word index is w = column and the row fold is f = row[7:0] XOR row[12:8]. The output is P(w XOR f), where P(i) = {i^8'hA5, i, ~i, i+8'h3C}.
- R7: In 16-bit mode the column is addr_i[8:0] and w = column[8:1]. Column bit 0 selects the upper (1) or lower (0) half of P, and that half appears on data_o[15:0] with data_o[31:16] = 0.
- R8: On the 3 edges that follow a taken mode set, every command is rejected.
- R9: An activate is rejected until tRC edges have passed since the last taken activate. tRC is 6 for BL 4 and 10 for BL 8, plus 1 when the row latency is 2.
- R10: A read is rejected when no row has been opened since reset. It is also rejected when fewer edges than the row latency have passed since the activate.
- R11: Any command is rejected while a read is waiting for its latency or delivering its burst.
- R12: On an edge with cke_i low, the block holds all of its state: data_o and valid_o are held, the burst position does not advance, and commands are not taken.
- R13: When mask_i is high on an edge that delivers a word, data_o is 0 for that word, valid_o stays 1, and the burst goes on.
- R14: A rejected command drives err_o high for the following cycle and changes no mode, row or burst state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low suspends the block |
| sel_i | input | 1 | Chip select, active high |
| mode_stb_i | input | 1 | Mode-register set strobe |
| row_stb_i | input | 1 | Activate (row) strobe |
| col_stb_i | input | 1 | Read (column) strobe |
| mask_i | input | 1 | Blanks the word delivered on this edge |
| word_mode_i | input | 1 | 1 selects 16-bit organisation, sampled at read |
| addr_i | input | 13 | Multiplexed row / column / mode address |
| data_o | output | 32 | Read data |
| valid_o | output | 1 | Burst word valid |
| err_o | output | 1 | Previous edge rejected a command |

## Verification
The bench sweeps all 32 mode settings in both organisations and checks the first-word cycle, every beat and the end of the burst against a model in the bench. A design that is off by one in latency would show valid_o one cycle early or late. A design with a wrong order would return a different word at the beat where the burst index wraps. Separate cases probe timing-rule boundaries: the edge just before a guard expires and the edge on which it expires, an early activate or read, and a mode set during a burst. For each one the bench then reads to confirm that the rejected command left the row and mode unchanged. Mask and suspend are placed in the middle of a burst to catch a design that drops a beat or moves on during a frozen clock.

// File: rtl/burst_rom_pkg.sv
package burst_rom_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BURST} seq_st_e;

  typedef struct packed {
    logic [1:0] cl_code;
    logic       rl2;
    logic       ilv;
    logic       bl8;
  } mode_t;

  localparam mode_t MODE_RST = '0;

  function automatic logic [WORD_W-1:0] pattern_word(input logic [7:0] idx);
    logic [7:0] inv;
    logic [7:0] ofs;
    inv = ~idx;
    ofs = idx + 8'h3C;
    return {idx ^ 8'hA5, idx, inv, ofs};
  endfunction

endpackage

// File: rtl/brc_cmd_ctrl.sv
module brc_cmd_ctrl
  import burst_rom_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int ROW_W   = 13,
  parameter int MRS_GAP = 3,
  parameter int TRC_BL4 = 6,
  parameter int TRC_BL8 = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             sel_i,
  input  logic             mode_stb_i,
  input  logic             row_stb_i,
  input  logic             col_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic             busy_i,
  output logic [1:0]       cl_code_o,
  output logic             ilv_o,
  output logic             bl8_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rd_go_o,
  output logic             err_o
);

  localparam int GW = $clog2(TRC_BL8 + 2) + 1;
  localparam int MW = $clog2(MRS_GAP + 1);

  mode_t            mode_q;
  logic [ROW_W-1:0] row_q;
  logic             row_open_q;
  logic [MW-1:0]    guard_q;
  logic [GW-1:0]    gap_q;
  logic             rlat_q;
  logic             err_q;

  logic is_mrs, is_act, is_rd, any_cmd;
  logic mrs_ok, act_ok, rd_ok, bad;
  logic [GW-1:0] trc_w;

  always_comb begin
    is_mrs  = sel_i &  mode_stb_i & ~row_stb_i & ~col_stb_i;
    is_act  = sel_i & ~mode_stb_i &  row_stb_i & ~col_stb_i;
    is_rd   = sel_i & ~mode_stb_i & ~row_stb_i &  col_stb_i;
    any_cmd = is_mrs | is_act | is_rd;
    mrs_ok  = is_mrs && guard_q == '0 && !busy_i;
    act_ok  = is_act && guard_q == '0 && gap_q == '0 && !busy_i;
    rd_ok   = is_rd && guard_q == '0 && row_open_q && !rlat_q && !busy_i;
    bad     = any_cmd && !(mrs_ok || act_ok || rd_ok);
    trc_w   = (mode_q.bl8 ? GW'(TRC_BL8) : GW'(TRC_BL4)) + GW'(mode_q.rl2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_RST;
      row_q      <= '0;
      row_open_q <= 1'b0;
      guard_q    <= '0;
      gap_q      <= '0;
      rlat_q     <= 1'b0;
      err_q      <= 1'b0;
    end else if (cke_i) begin
      err_q <= bad;
      if (guard_q != '0) guard_q <= guard_q - MW'(1);
      if (gap_q != '0)   gap_q   <= gap_q - GW'(1);
      if (rlat_q)        rlat_q  <= 1'b0;
      if (mrs_ok) begin
        mode_q  <= mode_t'(addr_i[4:0]);
        guard_q <= MW'(MRS_GAP);
      end
      if (act_ok) begin
        row_q      <= addr_i[ROW_W-1:0];
        row_open_q <= 1'b1;
        gap_q      <= trc_w - GW'(1);
        rlat_q     <= mode_q.rl2;
      end
    end else begin
      err_q <= 1'b0;
    end
  end

  assign cl_code_o = mode_q.cl_code;
  assign ilv_o     = mode_q.ilv;
  assign bl8_o     = mode_q.bl8;
  assign row_o     = row_q;
  assign rd_go_o   = cke_i & rd_ok;
  assign err_o     = err_q;

  // R8: a command inside the post-mode-set window must be flagged
  p_guard_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && guard_q != '0 && any_cmd) |=> err_q);

  // R3, R14: mode only changes through an accepted mode set
  p_mode_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cke_i && mrs_ok) |=> $stable(mode_q));

endmodule

// File: rtl/brc_burst_seq.sv
module brc_burst_seq
  import burst_rom_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cke_i,
  input  logic           rd_go_i,
  input  logic [COL_W:0] col_i,
  input  logic           word_mode_i,
  input  logic [1:0]     cl_code_i,
  input  logic           ilv_i,
  input  logic           bl8_i,
  output logic           busy_o,
  output logic           emit_o,
  output logic [COL_W:0] col_o,
  output logic           wm_o
);

  seq_st_e        st_q;
  logic [2:0]     lat_q;
  logic [3:0]     beat_q;
  logic [COL_W:0] base_q;
  logic           wm_q, ilv_q, bl8_q;

  logic [3:0] bl_n;
  logic [2:0] k, msk, off;

  always_comb begin
    bl_n   = bl8_q ? 4'd8 : 4'd4;
    k      = (st_q == ST_WAIT) ? 3'd0 : beat_q[2:0];
    msk    = bl8_q ? 3'd7 : 3'd3;
    off    = (ilv_q ? (base_q[2:0] ^ k) : (base_q[2:0] + k)) & msk;
    col_o  = {base_q[COL_W:3], (base_q[2:0] & ~msk) | off};
    emit_o = (st_q == ST_WAIT && lat_q == '0) ||
             (st_q == ST_BURST && beat_q != bl_n);
    busy_o = st_q != ST_IDLE;
    wm_o   = wm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      lat_q  <= '0;
      beat_q <= '0;
      base_q <= '0;
      wm_q   <= 1'b0;
      ilv_q  <= 1'b0;
      bl8_q  <= 1'b0;
    end else if (cke_i) begin
      unique case (st_q)
        ST_IDLE: if (rd_go_i) begin
          base_q <= word_mode_i ? col_i : {1'b0, col_i[COL_W-1:0]};
          wm_q   <= word_mode_i;
          ilv_q  <= ilv_i;
          bl8_q  <= bl8_i;
          lat_q  <= {1'b0, cl_code_i} + 3'd2;
          beat_q <= '0;
          st_q   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (lat_q == '0) begin
            st_q   <= ST_BURST;
            beat_q <= 4'd1;
          end else begin
            lat_q <= lat_q - 3'd1;
          end
        end
        ST_BURST: begin
          if (beat_q == bl_n) st_q <= ST_IDLE;
          else                beat_q <= beat_q + 4'd1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R12: a suspended edge moves neither state nor burst position
  p_suspend_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> ($stable(beat_q) && $stable(st_q) && $stable(lat_q)));

  // R4: burst position never runs past the longest burst
  p_beat_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_q <= 4'd8);

endmodule

// File: rtl/brc_pattern_rom.sv
module brc_pattern_rom
  import burst_rom_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);

  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] rom_a [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign rom_a[g] = pattern_word(8'(g));
  end

  assign word_o = rom_a[idx_i];

endmodule

// File: rtl/burst_rom_ctrl.sv
module burst_rom_ctrl
  import burst_rom_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 8,
  parameter int MRS_GAP = 3,
  parameter int TRC_BL4 = 6,
  parameter int TRC_BL8 = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              sel_i,
  input  logic              mode_stb_i,
  input  logic              row_stb_i,
  input  logic              col_stb_i,
  input  logic              mask_i,
  input  logic              word_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [31:0]       data_o,
  output logic              valid_o,
  output logic              err_o
);

  localparam int HALF_W = WORD_W / 2;

  logic [1:0]        cl_code;
  logic              ilv, bl8, rd_go, busy, emit, wm;
  logic [ROW_W-1:0]  row;
  logic [COL_W:0]    cur_col;
  logic [COL_W-1:0]  row_fold, word_idx;
  logic [WORD_W-1:0] rom_word, rd_data;
  logic [WORD_W-1:0] data_q;
  logic              valid_q;

  brc_cmd_ctrl #(
    .ADDR_W (ADDR_W), .ROW_W (ROW_W), .MRS_GAP (MRS_GAP),
    .TRC_BL4(TRC_BL4), .TRC_BL8(TRC_BL8)
  ) u_cmd (
    .clk_i, .rst_ni, .cke_i, .sel_i, .mode_stb_i, .row_stb_i, .col_stb_i,
    .addr_i, .busy_i(busy), .cl_code_o(cl_code), .ilv_o(ilv), .bl8_o(bl8),
    .row_o(row), .rd_go_o(rd_go), .err_o
  );

  brc_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk_i, .rst_ni, .cke_i, .rd_go_i(rd_go), .col_i(addr_i[COL_W:0]),
    .word_mode_i, .cl_code_i(cl_code), .ilv_i(ilv), .bl8_i(bl8),
    .busy_o(busy), .emit_o(emit), .col_o(cur_col), .wm_o(wm)
  );

  // fold every row bit into the column-wide index
  always_comb begin
    row_fold = '0;
    for (int i = 0; i < ROW_W; i++) row_fold[i % COL_W] ^= row[i];
    word_idx = (wm ? cur_col[COL_W:1] : cur_col[COL_W-1:0]) ^ row_fold;
  end

  brc_pattern_rom #(.IDX_W(COL_W)) u_rom (
    .idx_i (word_idx),
    .word_o(rom_word)
  );

  always_comb begin
    if (wm) rd_data = {{HALF_W{1'b0}},
                       cur_col[0] ? rom_word[WORD_W-1:HALF_W] : rom_word[HALF_W-1:0]};
    else    rd_data = rom_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (cke_i) begin
      valid_q <= emit;
      data_q  <= (emit && !mask_i) ? rd_data : '0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R13: masked delivery keeps valid and zeroes data
  p_mask_blank_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && emit && mask_i) |=> (valid_o && data_o == '0));

  // R12: outputs frozen across a suspended edge
  p_out_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> ($stable(valid_o) && $stable(data_o)));

endmodule

// File: tb/burst_rom_ctrl_bench.sv
`timescale 1ns/1ps
module burst_rom_ctrl_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke_i = 1'b1;
  logic        sel_i = 1'b0;
  logic        mode_stb_i = 1'b0;
  logic        row_stb_i = 1'b0;
  logic        col_stb_i = 1'b0;
  logic        mask_i = 1'b0;
  logic        word_mode_i = 1'b0;
  logic [12:0] addr_i = '0;
  logic [31:0] data_o;
  logic        valid_o;
  logic        err_o;

  int total = 0;
  int bad   = 0;

  always #4 clk_i = ~clk_i;

  burst_rom_ctrl u_burst_rom_ctrl (.*);

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // kind: 0 mode set, 1 activate, 2 read
  task automatic cmd(input int kind, input int a, input bit s = 1'b1);
    sel_i      = s;
    mode_stb_i = (kind == 0);
    row_stb_i  = (kind == 1);
    col_stb_i  = (kind == 2);
    addr_i     = 13'(a);
    tick();
    sel_i = 1'b0; mode_stb_i = 1'b0; row_stb_i = 1'b0; col_stb_i = 1'b0;
    addr_i = '0;
  endtask

  function automatic logic [31:0] exp_word(int row, int col, bit wm, int k, bit bl8, bit ilv);
    int m, s, o, c, w, f, i;
    logic [7:0] b, nb, bs;
    logic [31:0] p;
    m = bl8 ? 7 : 3;
    c = wm ? (col & 511) : (col & 255);
    s = c & m;
    o = ilv ? ((s ^ k) & m) : ((s + k) & m);
    c = (c & ~m) | o;
    w = wm ? ((c >> 1) & 255) : (c & 255);
    f = (row & 255) ^ ((row >> 8) & 31);
    i = (w ^ f) & 255;
    b = 8'(i); nb = ~b; bs = b + 8'h3C;
    p = {b ^ 8'hA5, b, nb, bs};
    if (wm) return (c & 1) ? {16'h0, p[31:16]} : {16'h0, p[15:0]};
    return p;
  endfunction

  // issue a read and check latency, every beat and burst end
  task automatic rd_check(input int row, input int col, input bit wm, input int md,
                          input int mask_beat = -1, input int susp_beat = -1);
    int cl, bl;
    bit bl8, ilv;
    logic [31:0] e;
    cl  = ((md >> 3) & 3) + 3;
    bl8 = md[0];
    ilv = md[1];
    bl  = bl8 ? 8 : 4;
    word_mode_i = wm;
    cmd(2, col);
    word_mode_i = 1'b0;
    chk("R2 read accepted", 32'(err_o), 32'd0);
    for (int i = 1; i < cl; i++) begin
      tick();
      chk("R4 no data before latency", 32'(valid_o), 32'd0);
    end
    for (int b = 0; b < bl; b++) begin
      mask_i = (b == mask_beat);
      tick();
      mask_i = 1'b0;
      e = (b == mask_beat) ? 32'h0 : exp_word(row, col, wm, b, bl8, ilv);
      chk("R4 beat valid", 32'(valid_o), 32'd1);
      if (b == mask_beat) chk("R13 masked word", data_o, e);
      else if (wm)        chk("R7 half word", data_o, e);
      else                chk("R5 R6 burst word", data_o, e);
      if (b == susp_beat) begin
        cke_i = 1'b0;
        for (int j = 0; j < 2; j++) begin
          tick();
          chk("R12 valid held", 32'(valid_o), 32'd1);
          chk("R12 data held", data_o, e);
        end
        cke_i = 1'b1;
      end
    end
    tick();
    chk("R4 burst end", 32'(valid_o), 32'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int row, col, rl;
    idle(2);
    chk("R1 reset valid", 32'(valid_o), 32'd0);
    chk("R1 reset data", data_o, 32'd0);
    chk("R1 reset err", 32'(err_o), 32'd0);
    rst_ni = 1'b1;
    idle(1);

    // R10: read with no open row
    cmd(2, 5);
    chk("R10 read without row", 32'(err_o), 32'd1);
    tick();
    chk("R14 err one cycle", 32'(err_o), 32'd0);
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R14 rejected read gives no data", 32'(valid_o), 32'd0);
    end

    // R1: default mode read
    cmd(1, 13'h0ABC);
    chk("R1 act accepted", 32'(err_o), 32'd0);
    rd_check(13'h0ABC, 8'h3E, 1'b0, 0);

    // R8: guard after mode set, rejected mode set has no effect
    idle(2);
    cmd(0, 5'b01000);
    chk("R3 mode set accepted", 32'(err_o), 32'd0);
    cmd(0, 5'b00011);
    chk("R8 mode set in guard", 32'(err_o), 32'd1);
    tick();
    cmd(1, 13'h0123);
    chk("R8 act on last guard edge", 32'(err_o), 32'd1);
    cmd(1, 13'h0123);
    chk("R8 act after guard", 32'(err_o), 32'd0);
    rd_check(13'h0123, 8'h47, 1'b0, 5'b01000);

    // R10: row latency 2
    idle(12);
    cmd(0, 5'b00100);
    idle(3);
    cmd(1, 13'h1F00);
    cmd(2, 8'h10);
    chk("R10 read before row latency", 32'(err_o), 32'd1);
    rd_check(13'h1F00, 8'h11, 1'b0, 5'b00100);

    // R9: activate spacing, BL 4
    idle(12);
    cmd(0, 5'b00000);
    idle(3);
    cmd(1, 13'h0555);
    idle(4);
    cmd(1, 13'h0AAA);
    chk("R9 act at tRC-1 (BL4)", 32'(err_o), 32'd1);
    rd_check(13'h0555, 8'h82, 1'b0, 0);
    cmd(1, 13'h0AAA);
    chk("R9 act after tRC", 32'(err_o), 32'd0);
    rd_check(13'h0AAA, 8'h82, 1'b0, 0);

    // R9: activate spacing, BL 8
    idle(12);
    cmd(0, 5'b00001);
    idle(3);
    cmd(1, 13'h0777);
    idle(8);
    cmd(1, 13'h0888);
    chk("R9 act at tRC-1 (BL8)", 32'(err_o), 32'd1);
    cmd(1, 13'h0888);
    chk("R9 act at tRC (BL8)", 32'(err_o), 32'd0);
    rd_check(13'h0888, 8'h25, 1'b0, 5'b00001);

    // R2: strobe with select low is ignored
    idle(12);
    cmd(1, 13'h1234, 1'b0);
    chk("R2 deselected act no err", 32'(err_o), 32'd0);
    rd_check(13'h0888, 8'h61, 1'b0, 5'b00001);

    // R11: mode set during a burst is rejected and ignored
    idle(12);
    cmd(0, 5'b00000);
    idle(3);
    cmd(1, 13'h0042);
    cmd(2, 8'h09);
    cmd(0, 5'b11111);
    chk("R11 mode set while busy", 32'(err_o), 32'd1);
    idle(10);
    rd_check(13'h0042, 8'h0A, 1'b0, 0);

    // R13, R12: mask and suspend inside a burst
    idle(12);
    cmd(0, 5'b01011);
    idle(3);
    cmd(1, 13'h1357);
    rd_check(13'h1357, 8'hC5, 1'b0, 5'b01011, 2, 4);
    idle(14);
    cmd(1, 13'h0246);
    rd_check(13'h0246, 9'h1D3, 1'b1, 5'b01011, 0, 6);

    // sweep every mode in both organisations
    for (int wm = 0; wm < 2; wm++) begin
      for (int md = 0; md < 32; md++) begin
        for (int t = 0; t < 2; t++) begin
          col = (md * 37 + t * 91 + wm * 13) % 512;
          row = (md * 523 + t * 2711 + wm * 97) % 8192;
          rl  = md[2] ? 2 : 1;
          idle(2);
          cmd(0, md);
          chk("R3 sweep mode set", 32'(err_o), 32'd0);
          idle(3);
          cmd(1, row);
          chk("R10 sweep act", 32'(err_o), 32'd0);
          idle(rl - 1);
          rd_check(row, col, wm[0], md);
        end
      end
    end

    summary();
    $finish;
  end

endmodule